// File: doc/BRIEF.md
# Condition Flag Evaluator

This block derives the condition flags that follow an arithmetic, logic, multiply or bit-test operation and merges them into a status register that it holds. The caller presents an operation code, an operand size, the source, destination and result values, and, for multiplies, the upper half of the product. It asserts `eval_i` for one cycle. Carry and overflow come from the sign bits of the operands and the result, not from a carry chain, so the block sits beside an ALU and needs none of its internals.

Each evaluation names the status bits it may change through a per-operation update mask. The X bit is always added to that mask, so every evaluation clears X. In extended-arithmetic mode a freshly computed Z of 1 is withheld, so that a chain of extended operations can only keep or clear Z. Bit test has its own rule: it ignores the mask, and it clears V and C only on older core revisions. A direct load port lets the surrounding pipeline restore the register.

Top module: `flag_eval_top`

## Requirements
- R1: While `rst_ni` is low and after reset, `stat_o` is 0 and `upd_o` is 0.
- R2: For add (op 0), sign bits are taken at bit 7 (size 0), bit 15 (size 1) or bit 31 (size 2 or 3). With the result sign set, N is set, V is set if both operand signs are clear, and otherwise C is set if both are set. With the result sign clear, V is set if both operand signs are set and C is set if either is set. Positions are C=0, V=1, Z=2, N=3, X=4, R=8.
- R3: Z is set only when the result sign bit is clear and the result bits up to the operand size are all zero; bits above the size are ignored.
- R4: Subtract (op 1) and compare (op 2) apply the add rules with the source inverted, then invert C.
- R5: MCP (op 3) applies the add rules but writes the carry term into R (bit 8); C is then changed only if the mask selects it.
- R6: Move/logic/shift (op 4) computes only N (size sign bit) and Z; its V and C terms are 0.
- R7: Signed multiply (op 5) takes N and Z from the 64-bit value {mul_hi_i, res_i} and sets V when mul_hi_i is not the sign extension of res_i.
- R8: Unsigned multiply (op 6) sets Z when the 64-bit value is zero, N from bit 31 of mul_hi_i, and V whenever mul_hi_i is nonzero.
- R9: For ops 0 to 6, the bits written are those set in `flag_mask_i` plus X. All other bits keep their value, and X ends up cleared.
- R10: With `ext_i` high and a computed Z of 1, Z keeps its old value; a computed Z of 0 still clears it when the mask selects Z.
- R11: Bit test (op 7) ignores `flag_mask_i`. It sets N to `dst_i[src_i[4:0]]` and sets Z when that bit and all lower bits are zero. It clears X, and it clears V and C only when `rev_i` < 32. All other bits are kept.
- R12: The status register updates on the clock edge after `eval_i`, and `upd_o` pulses for that cycle. `load_i` overrides `eval_i` and loads `load_val_i`. With neither input high the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate flags this cycle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 mcp, 4 move/logic, 5 muls, 6 mulu, 7 bit test) |
| size_i | input | 2 | Operand size (0 byte, 1 half, 2/3 word) |
| src_i | input | DATA_W | Source operand (bit index for bit test) |
| dst_i | input | DATA_W | Destination operand (tested value for bit test) |
| res_i | input | DATA_W | Result, low product word for multiplies |
| mul_hi_i | input | DATA_W | High product word |
| flag_mask_i | input | STAT_W | Status bits this operation may update |
| ext_i | input | 1 | Extended-arithmetic mode |
| rev_i | input | REV_W | Core revision number |
| load_i | input | 1 | Load status register directly |
| load_val_i | input | STAT_W | Value for a direct load |
| stat_o | output | STAT_W | Status register |
| upd_o | output | 1 | An evaluation was applied last cycle |

## Verification
The bench uses the defaults: 32-bit data, a 16-bit status word with R at bit 8, X at bit 4, and a revision threshold of 32. With these values the byte, half and word sign positions can each be driven, along with the carry that lands in R for MCP and the status bits above R that no flag touches. The 8-bit revision input reaches both sides of the threshold, so the bit-test V/C rule is covered in both forms. The bench also tests bit index 31 and result values with set bits above the operand size.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_MCP  = 3'd3,
        OP_MOVE = 3'd4,
        OP_MULS = 3'd5,
        OP_MULU = 3'd6,
        OP_BTST = 3'd7
    } fe_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } fe_size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } fe_flags_t;

endpackage

// File: rtl/flag_sign_table.sv
module flag_sign_table
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_i,
    input  logic              inv_src_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    output fe_flags_t         flags_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [DATA_W-1:0] src_eff;
    logic s_sgn, d_sgn, r_sgn, r_zero;

    assign src_eff = inv_src_i ? ~src_i : src_i;

    always_comb begin
        case (fe_size_e'(size_i))
            SZ_BYTE: begin
                s_sgn  = src_eff[BYTE_W-1];
                d_sgn  = dst_i[BYTE_W-1];
                r_sgn  = res_i[BYTE_W-1];
                r_zero = (res_i[BYTE_W-1:0] == '0);
            end
            SZ_HALF: begin
                s_sgn  = src_eff[HALF_W-1];
                d_sgn  = dst_i[HALF_W-1];
                r_sgn  = res_i[HALF_W-1];
                r_zero = (res_i[HALF_W-1:0] == '0);
            end
            default: begin
                s_sgn  = src_eff[DATA_W-1];
                d_sgn  = dst_i[DATA_W-1];
                r_sgn  = res_i[DATA_W-1];
                r_zero = (res_i == '0);
            end
        endcase
    end

    always_comb begin
        flags_o = '0;
        if (r_sgn) begin
            flags_o.n = 1'b1;
            if (!s_sgn && !d_sgn) flags_o.v = 1'b1;
            else if (s_sgn && d_sgn) flags_o.c = 1'b1;
        end else begin
            flags_o.z = r_zero;
            flags_o.v = s_sgn & d_sgn;
            flags_o.c = s_sgn | d_sgn;
        end
    end
endmodule

// File: rtl/flag_mul.sv
module flag_mul
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              signed_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    output fe_flags_t         flags_o
);
    logic wide_zero, hi_is_ext;

    assign wide_zero = (hi_i == '0) && (lo_i == '0);
    assign hi_is_ext = lo_i[DATA_W-1] ? (&hi_i) : (hi_i == '0);

    always_comb begin
        flags_o   = '0;
        flags_o.z = wide_zero;
        flags_o.n = !wide_zero && hi_i[DATA_W-1];
        flags_o.v = signed_i ? !hi_is_ext : (hi_i != '0);
    end
endmodule

// File: rtl/flag_bittest.sv
module flag_bittest #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              n_o,
    output logic              z_o
);
    logic [DATA_W-1:0] low_mask;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            low_mask[i] = (i <= int'(idx_i));
        end
    end

    assign n_o = val_i[idx_i];
    assign z_o = ((val_i & low_mask) == '0);
endmodule

// File: rtl/flag_eval_top.sv
module flag_eval_top
    import flag_eval_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int STAT_W       = 16,
    parameter int C_BIT        = 0,
    parameter int V_BIT        = 1,
    parameter int Z_BIT        = 2,
    parameter int N_BIT        = 3,
    parameter int X_BIT        = 4,
    parameter int R_BIT        = 8,
    parameter int REV_W        = 8,
    parameter int BT_REV_LIMIT = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              eval_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] mul_hi_i,
    input  logic [STAT_W-1:0] flag_mask_i,
    input  logic              ext_i,
    input  logic [REV_W-1:0]  rev_i,
    input  logic              load_i,
    input  logic [STAT_W-1:0] load_val_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              upd_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [REV_W-1:0] REV_LIM = REV_W'(BT_REV_LIMIT);
    localparam logic [STAT_W-1:0] ONE = STAT_W'(1);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              upd;
    } state_t;

    state_t state_d, state_q;
    fe_op_e op;
    fe_flags_t tbl_flags, mul_flags;
    logic bt_n, bt_z, inv_src;
    logic [STAT_W-1:0] flag_vec, wmask, merged;

    assign op      = fe_op_e'(op_i);
    assign inv_src = (op == OP_SUB) || (op == OP_CMP);

    flag_sign_table #(.DATA_W(DATA_W)) u_sign (
        .size_i   (size_i),
        .inv_src_i(inv_src),
        .src_i    (src_i),
        .dst_i    (dst_i),
        .res_i    (res_i),
        .flags_o  (tbl_flags)
    );

    flag_mul #(.DATA_W(DATA_W)) u_mul (
        .signed_i(op == OP_MULS),
        .lo_i    (res_i),
        .hi_i    (mul_hi_i),
        .flags_o (mul_flags)
    );

    flag_bittest #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_btst (
        .val_i(dst_i),
        .idx_i(src_i[IDX_W-1:0]),
        .n_o  (bt_n),
        .z_o  (bt_z)
    );

    // Computed flag vector for the sign-rule and multiply operations
    always_comb begin
        flag_vec = '0;
        case (op)
            OP_ADD: begin
                flag_vec[N_BIT] = tbl_flags.n;
                flag_vec[Z_BIT] = tbl_flags.z;
                flag_vec[V_BIT] = tbl_flags.v;
                flag_vec[C_BIT] = tbl_flags.c;
            end
            OP_SUB, OP_CMP: begin
                flag_vec[N_BIT] = tbl_flags.n;
                flag_vec[Z_BIT] = tbl_flags.z;
                flag_vec[V_BIT] = tbl_flags.v;
                flag_vec[C_BIT] = !tbl_flags.c;
            end
            OP_MCP: begin
                flag_vec[N_BIT] = tbl_flags.n;
                flag_vec[Z_BIT] = tbl_flags.z;
                flag_vec[V_BIT] = tbl_flags.v;
                flag_vec[R_BIT] = tbl_flags.c;
            end
            OP_MOVE: begin
                flag_vec[N_BIT] = tbl_flags.n;
                flag_vec[Z_BIT] = tbl_flags.z;
            end
            OP_MULS, OP_MULU: begin
                flag_vec[N_BIT] = mul_flags.n;
                flag_vec[Z_BIT] = mul_flags.z;
                flag_vec[V_BIT] = mul_flags.v;
            end
            default: flag_vec = '0;
        endcase
    end

    // Write mask and merge into the held status word
    always_comb begin
        wmask = flag_mask_i | (ONE << X_BIT);
        if (ext_i && flag_vec[Z_BIT]) wmask[Z_BIT] = 1'b0;
        merged = (state_q.stat & ~wmask) | (flag_vec & wmask);
        if (op == OP_BTST) begin
            merged = state_q.stat;
            merged[X_BIT] = 1'b0;
            merged[N_BIT] = bt_n;
            merged[Z_BIT] = bt_z;
            if (rev_i < REV_LIM) begin
                merged[V_BIT] = 1'b0;
                merged[C_BIT] = 1'b0;
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.upd = eval_i && !load_i;
        if (load_i)      state_d.stat = load_val_i;
        else if (eval_i) state_d.stat = merged;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign stat_o = state_q.stat;
    assign upd_o  = state_q.upd;

    // Bits outside the write mask are untouched by an evaluation
    assert_mask_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && !load_i && op != OP_BTST)
        |=> (((state_q.stat ^ $past(state_q.stat)) & ~$past(wmask)) == '0));

    // Any applied evaluation leaves X clear
    assert_x_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && !load_i) |=> !state_q.stat[X_BIT]);

    // Extended mode never raises Z
    assert_ext_no_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && !load_i && ext_i && op != OP_BTST && !state_q.stat[Z_BIT])
        |=> !state_q.stat[Z_BIT]);

    // MCP leaves C alone unless the mask selects it
    assert_mcp_c_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eval_i && !load_i && op == OP_MCP && !flag_mask_i[C_BIT])
        |=> $stable(state_q.stat[C_BIT]));

    // Load takes priority
    assert_load_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (state_q.stat == $past(load_val_i)));

    // Idle holds the register
    assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !eval_i) |=> ($stable(state_q.stat) && !state_q.upd));
endmodule

// File: tb/test_flag_eval_top.sv
module test_flag_eval_top;
    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        eval_i;
    logic [2:0]  op_i;
    logic [1:0]  size_i;
    logic [31:0] src_i, dst_i, res_i, mul_hi_i;
    logic [15:0] flag_mask_i;
    logic        ext_i;
    logic [7:0]  rev_i;
    logic        load_i;
    logic [15:0] load_val_i;
    logic [15:0] stat_o;
    logic        upd_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk_i = ~clk_i;

    flag_eval_top i_flag_eval_top (
        .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval_i), .op_i(op_i),
        .size_i(size_i), .src_i(src_i), .dst_i(dst_i), .res_i(res_i),
        .mul_hi_i(mul_hi_i), .flag_mask_i(flag_mask_i), .ext_i(ext_i),
        .rev_i(rev_i), .load_i(load_i), .load_val_i(load_val_i),
        .stat_o(stat_o), .upd_o(upd_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] v);
        load_i = 1'b1; load_val_i = v;
        @(posedge clk_i); @(negedge clk_i);
        load_i = 1'b0;
    endtask

    task automatic do_eval(input logic [2:0] op, input logic [1:0] sz,
                           input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] r, input logic [31:0] hi,
                           input logic [15:0] m, input logic ex, input logic [7:0] rev);
        op_i = op; size_i = sz; src_i = s; dst_i = d; res_i = r;
        mul_hi_i = hi; flag_mask_i = m; ext_i = ex; rev_i = rev; eval_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        eval_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 stat in reset", stat_o, 16'h0);
        check("R1 upd in reset", {15'd0, upd_o}, 16'h0);
    endtask

    task automatic t_add;
        do_load(16'h0010);
        do_eval(3'd0, 2'd0, 32'h7F, 32'h01, 32'h80, 0, 16'h000F, 0, 8'd40);
        check("R2 byte add overflow", stat_o, 16'h000A);
        check("R12 upd pulse", {15'd0, upd_o}, 16'h1);
        @(negedge clk_i);
        check("R12 upd falls", {15'd0, upd_o}, 16'h0);
        do_load(16'h0);
        do_eval(3'd0, 2'd0, 32'hFF, 32'h01, 32'h100, 0, 16'h000F, 0, 8'd40);
        check("R3 byte zero with upper bits", stat_o, 16'h0005);
        do_eval(3'd0, 2'd1, 32'h8000, 32'h8000, 32'h10000, 0, 16'h000F, 0, 8'd40);
        check("R3 half zero V C", stat_o, 16'h0007);
        do_eval(3'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h80000001, 0, 16'h000F, 0, 8'd40);
        check("R2 word neg both signs", stat_o, 16'h0009);
    endtask

    task automatic t_sub;
        do_eval(3'd1, 2'd2, 32'd5, 32'd3, 32'hFFFFFFFE, 0, 16'h000F, 0, 8'd40);
        check("R4 sub borrow", stat_o, 16'h0009);
        do_eval(3'd1, 2'd2, 32'd3, 32'd5, 32'd2, 0, 16'h000F, 0, 8'd40);
        check("R4 sub no borrow", stat_o, 16'h0000);
        do_eval(3'd2, 2'd3, 32'd7, 32'd7, 32'd0, 0, 16'h000F, 0, 8'd40);
        check("R4 cmp equal", stat_o, 16'h0004);
    endtask

    task automatic t_mcp;
        do_load(16'h0001);
        do_eval(3'd3, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 0, 16'h010E, 0, 8'd40);
        check("R5 mcp carry to R", stat_o, 16'h0107);
    endtask

    task automatic t_move;
        do_load(16'h0003);
        do_eval(3'd4, 2'd1, 0, 0, 32'hFFFF8000, 0, 16'h000C, 0, 8'd40);
        check("R6 move half negative", stat_o, 16'h000B);
        do_eval(3'd4, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h100, 0, 16'h000F, 0, 8'd40);
        check("R6 move byte zero clears V C", stat_o, 16'h0004);
    endtask

    task automatic t_mul;
        do_eval(3'd5, 2'd2, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h000F, 0, 8'd40);
        check("R7 muls minus one", stat_o, 16'h0008);
        do_eval(3'd5, 2'd2, 0, 0, 32'h80000000, 32'h0, 16'h000F, 0, 8'd40);
        check("R7 muls not sign extended", stat_o, 16'h0002);
        do_eval(3'd5, 2'd2, 0, 0, 32'h0, 32'h0, 16'h000F, 0, 8'd40);
        check("R7 muls zero", stat_o, 16'h0004);
        do_eval(3'd6, 2'd2, 0, 0, 32'd5, 32'd1, 16'h000F, 0, 8'd40);
        check("R8 mulu high nonzero", stat_o, 16'h0002);
        do_eval(3'd6, 2'd2, 0, 0, 32'h0, 32'h80000000, 16'h000F, 0, 8'd40);
        check("R8 mulu top bit", stat_o, 16'h000A);
        do_eval(3'd6, 2'd2, 0, 0, 32'h0, 32'h0, 16'h000F, 0, 8'd40);
        check("R8 mulu zero", stat_o, 16'h0004);
    endtask

    task automatic t_mask;
        do_load(16'h0F1F);
        do_eval(3'd0, 2'd0, 32'h7F, 32'h01, 32'h80, 0, 16'h0008, 0, 8'd40);
        check("R9 only N and X written", stat_o, 16'h0F0F);
    endtask

    task automatic t_ext;
        do_load(16'h0004);
        do_eval(3'd0, 2'd0, 0, 0, 0, 0, 16'h000F, 1, 8'd40);
        check("R10 ext keeps Z set", stat_o, 16'h0004);
        do_load(16'h0000);
        do_eval(3'd0, 2'd0, 0, 0, 0, 0, 16'h000F, 1, 8'd40);
        check("R10 ext does not raise Z", stat_o, 16'h0000);
        do_load(16'h0004);
        do_eval(3'd0, 2'd0, 0, 0, 32'd1, 0, 16'h000F, 1, 8'd40);
        check("R10 ext clears Z on nonzero", stat_o, 16'h0000);
    endtask

    task automatic t_btst;
        do_load(16'h001F);
        do_eval(3'd7, 2'd2, 32'd4, 32'h10, 0, 0, 16'h0000, 0, 8'd10);
        check("R11 btst old rev clears V C", stat_o, 16'h0008);
        do_load(16'h001F);
        do_eval(3'd7, 2'd2, 32'd4, 32'h10, 0, 0, 16'h0000, 0, 8'd40);
        check("R11 btst new rev keeps V C", stat_o, 16'h000B);
        do_load(16'h001F);
        do_eval(3'd7, 2'd2, 32'd3, 32'h10, 0, 0, 16'h0000, 0, 8'd40);
        check("R11 btst low bits zero", stat_o, 16'h0007);
        do_load(16'h0113);
        do_eval(3'd7, 2'd2, 32'h3F, 32'h80000000, 0, 0, 16'h0000, 0, 8'd40);
        check("R11 btst index 31", stat_o, 16'h010B);
    endtask

    task automatic t_load_hold;
        do_load(16'h0000);
        load_i = 1'b1; load_val_i = 16'h0A55;
        op_i = 3'd0; size_i = 2'd0; src_i = 32'h7F; dst_i = 32'h1; res_i = 32'h80;
        flag_mask_i = 16'hFFFF; ext_i = 0; eval_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        load_i = 1'b0; eval_i = 1'b0;
        check("R12 load beats eval", stat_o, 16'h0A55);
        check("R12 no upd on load", {15'd0, upd_o}, 16'h0);
        repeat (3) @(negedge clk_i);
        check("R12 idle hold", stat_o, 16'h0A55);
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_ni = 1'b0; eval_i = 0; op_i = 0; size_i = 0; src_i = 0; dst_i = 0;
        res_i = 0; mul_hi_i = 0; flag_mask_i = 0; ext_i = 0; rev_i = 0;
        load_i = 0; load_val_i = 0;
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_add();
        t_sub();
        t_mcp();
        t_move();
        t_mul();
        t_mask();
        t_ext();
        t_btst();
        t_load_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule